// File: doc/BRIEF.md
# Egress QoS Field Rewriter

This block decides the final QoS header fields of a packet leaving the switch. For each packet it receives the port the packet arrived on, the 4-bit switch priority and 2-bit colour given to it on ingress, and the packet's original DSCP, PCP and DEI, plus a flag that says whether the packet carries an IP header. One clock later it returns the DSCP, PCP and DEI that the egress pipeline should write into the headers. It does not recompute checksums and does not add or strip tags.

Software sets up the block through two write strobes. The first sets a pair of rewrite switches for one receive port: one for DSCP and one for PCP with DEI. The second loads one priority row of that port's DSCP table. A row holds a separate DSCP value for each of the three colours, and a mask chooses which of the three values to update. Port numbers are 8 bits wide. Only the first `NUM_PORTS` numbers have storage, and the CPU port is simply one of them.

Top module: `qos_rewrite_top`

## Requirements
- R1: After reset `outValid`, `outDscp`, `outPcp` and `outDei` are 0, every port has both rewrite switches off, and every DSCP table slot holds 0.
- R2: `outValid` is high exactly in the cycle after a cycle with `pktValid` high, and that cycle carries that packet's result. When `pktValid` is low, `outDscp`, `outPcp` and `outDei` keep their previous values.
- R3: When the packet's port has DSCP rewrite on and `pktIsIp` is 1, `outDscp` is the table value at [port][priority][colour slot].
- R4: When DSCP rewrite is off for the port, or `pktIsIp` is 0, `outDscp` equals `pktDscp`.
- R5: When PCP rewrite is on for the port, `outPcp` is `pktPrio[2:0]`, and `outDei` is 1 for colours 1, 2 and 3 and 0 for colour 0.
- R6: When PCP rewrite is off for the port, `outPcp` equals `pktPcp` and `outDei` equals `pktDei`.
- R7: Colour value 3 uses the colour-2 table slot.
- R8: A table write to port `cfgTabPort` and row `cfgTabPrio` updates colour slot c, with data `cfgTabData[6c+5:6c]`, only if `cfgTabMask[c]` is 1. The other slots keep their values.
- R9: A switch write sets the DSCP switch of `cfgEnPort` to `cfgEnDscp` and its PCP/DEI switch to `cfgEnPcp`. Other ports are not affected.
- R10: A port number of `NUM_PORTS` or more has no storage. Writes to it are ignored, they do not alias onto a lower port, and its packets pass through unchanged.
- R11: A packet that arrives in the same cycle as a configuration write is processed with the configuration as it was before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgEnWe | input | 1 | Strobe that writes the rewrite switches |
| cfgEnPort | input | 8 | Port whose switches are written |
| cfgEnDscp | input | 1 | New value of the DSCP rewrite switch |
| cfgEnPcp | input | 1 | New value of the PCP/DEI rewrite switch |
| cfgTabWe | input | 1 | Strobe that writes one table row |
| cfgTabPort | input | 8 | Port of the table row |
| cfgTabPrio | input | 4 | Priority of the table row |
| cfgTabMask | input | 3 | Per-colour update mask; bit c selects colour c |
| cfgTabData | input | 18 | DSCP values; colour c at bits [6c+5:6c] |
| pktValid | input | 1 | A packet is presented this cycle |
| pktPort | input | 8 | Receive port of the packet |
| pktPrio | input | 4 | Switch priority of the packet |
| pktColour | input | 2 | Colour of the packet |
| pktDscp | input | 6 | Original DSCP |
| pktPcp | input | 3 | Original PCP |
| pktDei | input | 1 | Original DEI |
| pktIsIp | input | 1 | Packet has an IP header |
| outValid | output | 1 | Result strobe |
| outDscp | output | 6 | Final DSCP |
| outPcp | output | 3 | Final PCP |
| outDei | output | 1 | Final DEI |

## Verification
A corrupted table slot stays hidden until a packet with that exact port, priority and colour arrives on a port with DSCP rewrite on. The bench therefore reads back every slot a write touched, and the slots the mask left alone, one cycle after the write. A switch latched on the wrong port, or a port number aliased through truncation, shows as a wrong DSCP or PCP on the very next packet from the affected port. The bench sends that packet immediately. A mistake in the timing of a write against a packet in the same cycle changes the result of that one packet only, so a packet is placed on exactly that cycle.

// File: rtl/qos_rewrite_pkg.sv
package qos_rewrite_pkg;
  localparam int PRIO_W   = 4;
  localparam int NUM_PRIO = 1 << PRIO_W;
  localparam int COL_W    = 2;
  localparam int NUM_SLOT = 3;
  localparam int DSCP_W   = 6;
  localparam int PCP_W    = 3;

  // per-packet strobes from control to datapath
  typedef struct packed {
    logic             load;
    logic             rwDscp;
    logic             rwPcp;
    logic             setDei;
    logic [COL_W-1:0] colSlot;
  } pktCtl_t;

  // table write strobes from control to datapath
  typedef struct packed {
    logic                         we;
    logic [PRIO_W-1:0]            prio;
    logic [NUM_SLOT-1:0]          mask;
    logic [NUM_SLOT*DSCP_W-1:0]   data;
  } tabWr_t;
endpackage

// File: rtl/qos_rewrite_ctrl.sv
module qos_rewrite_ctrl
  import qos_rewrite_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 8,
  localparam int PIDX_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfgEnWe,
  input  logic [PORT_W-1:0]     cfgEnPort,
  input  logic                  cfgEnDscp,
  input  logic                  cfgEnPcp,
  input  logic                  cfgTabWe,
  input  logic [PORT_W-1:0]     cfgTabPort,
  input  logic [PRIO_W-1:0]     cfgTabPrio,
  input  logic [NUM_SLOT-1:0]   cfgTabMask,
  input  logic [NUM_SLOT*DSCP_W-1:0] cfgTabData,
  input  logic                  pktValid,
  input  logic [PORT_W-1:0]     pktPort,
  input  logic [COL_W-1:0]      pktColour,
  input  logic                  pktIsIp,
  output pktCtl_t               pktCtl,
  output logic [PIDX_W-1:0]     pktIdx,
  output tabWr_t                tabWr,
  output logic [PIDX_W-1:0]     tabIdx
);
  logic [NUM_PORTS-1:0] enDscp;
  logic [NUM_PORTS-1:0] enPcp;
  logic enInRange, tabInRange, pktInRange;
  logic [PIDX_W-1:0] enIdx;

  assign enInRange  = int'(cfgEnPort)  < NUM_PORTS;
  assign tabInRange = int'(cfgTabPort) < NUM_PORTS;
  assign pktInRange = int'(pktPort)    < NUM_PORTS;
  assign enIdx  = cfgEnPort[PIDX_W-1:0];
  assign tabIdx = cfgTabPort[PIDX_W-1:0];
  assign pktIdx = pktPort[PIDX_W-1:0];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_en
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        enDscp[p] <= 1'b0;
        enPcp[p]  <= 1'b0;
      end else if (cfgEnWe && enInRange && enIdx == PIDX_W'(p)) begin
        enDscp[p] <= cfgEnDscp;
        enPcp[p]  <= cfgEnPcp;
      end
    end
  end

  always_comb begin
    pktCtl.load    = pktValid;
    pktCtl.rwDscp  = pktInRange && enDscp[pktIdx] && pktIsIp;
    pktCtl.rwPcp   = pktInRange && enPcp[pktIdx];
    pktCtl.setDei  = pktColour != 2'd0;
    pktCtl.colSlot = (pktColour == 2'd3) ? 2'd2 : pktColour;
  end

  always_comb begin
    tabWr.we   = cfgTabWe && tabInRange;
    tabWr.prio = cfgTabPrio;
    tabWr.mask = cfgTabMask;
    tabWr.data = cfgTabData;
  end

  // R7
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pktCtl.colSlot != 2'd3);
endmodule

// File: rtl/qos_rewrite_dp.sv
module qos_rewrite_dp
  import qos_rewrite_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  localparam int PIDX_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  pktCtl_t             pktCtl,
  input  logic [PIDX_W-1:0]   pktIdx,
  input  tabWr_t              tabWr,
  input  logic [PIDX_W-1:0]   tabIdx,
  input  logic [PRIO_W-1:0]   pktPrio,
  input  logic [DSCP_W-1:0]   pktDscp,
  input  logic [PCP_W-1:0]    pktPcp,
  input  logic                pktDei,
  output logic                outValid,
  output logic [DSCP_W-1:0]   outDscp,
  output logic [PCP_W-1:0]    outPcp,
  output logic                outDei
);
  logic [DSCP_W-1:0] tab [NUM_PORTS][NUM_PRIO][NUM_SLOT];
  logic [DSCP_W-1:0] lookDscp;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    for (genvar q = 0; q < NUM_PRIO; q++) begin : g_prio
      for (genvar c = 0; c < NUM_SLOT; c++) begin : g_slot
        always_ff @(posedge clk) begin
          if (!rst_n)
            tab[p][q][c] <= '0;
          else if (tabWr.we && tabWr.mask[c] && tabIdx == PIDX_W'(p) &&
                   tabWr.prio == PRIO_W'(q))
            tab[p][q][c] <= tabWr.data[c*DSCP_W +: DSCP_W];
        end
      end
    end
  end

  assign lookDscp = tab[pktIdx][pktPrio][pktCtl.colSlot];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      outDscp  <= '0;
      outPcp   <= '0;
      outDei   <= 1'b0;
    end else begin
      outValid <= pktCtl.load;
      if (pktCtl.load) begin
        outDscp <= pktCtl.rwDscp ? lookDscp : pktDscp;
        outPcp  <= pktCtl.rwPcp ? pktPrio[PCP_W-1:0] : pktPcp;
        outDei  <= pktCtl.rwPcp ? pktCtl.setDei : pktDei;
      end
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pktCtl.load |=> outValid);
  // R2
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pktCtl.load |=> $stable(outDscp) && $stable(outPcp) && $stable(outDei));
  // R6
  pcp_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pktCtl.load && !pktCtl.rwPcp |=> outPcp == $past(pktPcp) && outDei == $past(pktDei));
endmodule

// File: rtl/qos_rewrite_top.sv
module qos_rewrite_top
  import qos_rewrite_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 8,
  localparam int PIDX_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfgEnWe,
  input  logic [7:0]   cfgEnPort,
  input  logic         cfgEnDscp,
  input  logic         cfgEnPcp,
  input  logic         cfgTabWe,
  input  logic [7:0]   cfgTabPort,
  input  logic [3:0]   cfgTabPrio,
  input  logic [2:0]   cfgTabMask,
  input  logic [17:0]  cfgTabData,
  input  logic         pktValid,
  input  logic [7:0]   pktPort,
  input  logic [3:0]   pktPrio,
  input  logic [1:0]   pktColour,
  input  logic [5:0]   pktDscp,
  input  logic [2:0]   pktPcp,
  input  logic         pktDei,
  input  logic         pktIsIp,
  output logic         outValid,
  output logic [5:0]   outDscp,
  output logic [2:0]   outPcp,
  output logic         outDei
);
  pktCtl_t           pktCtl;
  tabWr_t            tabWr;
  logic [PIDX_W-1:0] pktIdx, tabIdx;

  qos_rewrite_ctrl #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cfgEnWe(cfgEnWe), .cfgEnPort(cfgEnPort), .cfgEnDscp(cfgEnDscp), .cfgEnPcp(cfgEnPcp),
    .cfgTabWe(cfgTabWe), .cfgTabPort(cfgTabPort), .cfgTabPrio(cfgTabPrio),
    .cfgTabMask(cfgTabMask), .cfgTabData(cfgTabData),
    .pktValid(pktValid), .pktPort(pktPort), .pktColour(pktColour), .pktIsIp(pktIsIp),
    .pktCtl(pktCtl), .pktIdx(pktIdx), .tabWr(tabWr), .tabIdx(tabIdx)
  );

  qos_rewrite_dp #(.NUM_PORTS(NUM_PORTS)) u_dp (
    .clk(clk), .rst_n(rst_n),
    .pktCtl(pktCtl), .pktIdx(pktIdx), .tabWr(tabWr), .tabIdx(tabIdx),
    .pktPrio(pktPrio), .pktDscp(pktDscp), .pktPcp(pktPcp), .pktDei(pktDei),
    .outValid(outValid), .outDscp(outDscp), .outPcp(outPcp), .outDei(outDei)
  );

  // R4
  non_ip_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pktValid && !pktIsIp |=> outDscp == $past(pktDscp));
  // R10
  far_port_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pktValid && int'(pktPort) >= NUM_PORTS |=>
      outDscp == $past(pktDscp) && outPcp == $past(pktPcp) && outDei == $past(pktDei));
  // R2
  valid_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pktValid |=> !outValid);
endmodule

// File: tb/tb_qos_rewrite_top.sv
module tb_qos_rewrite_top;
  localparam int NP = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfgEnWe = 0, cfgEnDscp = 0, cfgEnPcp = 0;
  logic [7:0] cfgEnPort = 0;
  logic cfgTabWe = 0;
  logic [7:0] cfgTabPort = 0;
  logic [3:0] cfgTabPrio = 0;
  logic [2:0] cfgTabMask = 0;
  logic [17:0] cfgTabData = 0;
  logic pktValid = 0, pktDei = 0, pktIsIp = 0;
  logic [7:0] pktPort = 0;
  logic [3:0] pktPrio = 0;
  logic [1:0] pktColour = 0;
  logic [5:0] pktDscp = 0;
  logic [2:0] pktPcp = 0;
  logic outValid, outDei;
  logic [5:0] outDscp;
  logic [2:0] outPcp;

  int nCmp = 0, nBad = 0, cyc = 0;
  bit finished = 0;
  bit refEnD [NP];
  bit refEnP [NP];
  int refTab [NP][16][3];
  int eV = 0, eD = 0, eP = 0, eE = 0;

  always #2 clk = ~clk;

  qos_rewrite_top dut (.*);

  task automatic compare(string tag);
    nCmp++;
    if (outValid !== eV[0] || outDscp !== eD[5:0] || outPcp !== eP[2:0] || outDei !== eE[0]) begin
      nBad++;
      $display("FAIL %s: got v=%0d dscp=%0d pcp=%0d dei=%0d, expected v=%0d dscp=%0d pcp=%0d dei=%0d",
               tag, outValid, outDscp, outPcp, outDei, eV, eD, eP, eE);
    end
  endtask

  // one clock edge: model the edge from the applied inputs, then compare
  task automatic tick(string tag);
    @(posedge clk);
    if (pktValid) begin
      int p = pktPort;
      int col = (pktColour == 3) ? 2 : pktColour;
      bit inR = p < NP;
      eV = 1;
      eD = (inR && refEnD[p] && pktIsIp) ? refTab[p][pktPrio][col] : pktDscp;
      eP = (inR && refEnP[p]) ? (pktPrio & 7) : pktPcp;
      eE = (inR && refEnP[p]) ? (pktColour != 0) : pktDei;
    end else eV = 0;
    if (cfgEnWe && cfgEnPort < NP) begin
      refEnD[cfgEnPort] = cfgEnDscp;
      refEnP[cfgEnPort] = cfgEnPcp;
    end
    if (cfgTabWe && cfgTabPort < NP)
      for (int c = 0; c < 3; c++)
        if (cfgTabMask[c]) refTab[cfgTabPort][cfgTabPrio][c] = (cfgTabData >> (6*c)) & 63;
    #1;
    compare(tag);
    cfgEnWe = 0; cfgTabWe = 0; pktValid = 0;
  endtask

  task automatic setEn(int port, bit d, bit p);
    cfgEnWe = 1; cfgEnPort = port[7:0]; cfgEnDscp = d; cfgEnPcp = p;
  endtask

  task automatic setTab(int port, int prio, int mask, int d0, int d1, int d2);
    cfgTabWe = 1; cfgTabPort = port[7:0]; cfgTabPrio = prio[3:0]; cfgTabMask = mask[2:0];
    cfgTabData = {d2[5:0], d1[5:0], d0[5:0]};
  endtask

  task automatic pkt(int port, int prio, int col, int dscp, int pcp, bit dei, bit ip);
    pktValid = 1; pktPort = port[7:0]; pktPrio = prio[3:0]; pktColour = col[1:0];
    pktDscp = dscp[5:0]; pktPcp = pcp[2:0]; pktDei = dei; pktIsIp = ip;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      nBad++;
      $display("FAIL watchdog: got cycle %0d, expected end before 20000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < NP; p++) begin
      refEnD[p] = 0; refEnP[p] = 0;
      for (int q = 0; q < 16; q++) for (int c = 0; c < 3; c++) refTab[p][q][c] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    compare("R1 reset outputs");
    // R1: table is zero after reset
    setEn(1, 1, 1); tick("R9 enable write");
    pkt(1, 6, 1, 33, 2, 0, 1); tick("R1 table reset value");
    // R3 R7 R5: full row, every colour
    setTab(1, 5, 7, 10, 20, 30); tick("R8 full write");
    for (int c = 0; c < 4; c++) begin
      pkt(1, 5, c, 1, 7, 0, 1); tick("R3 R5 R7 colour lookup");
    end
    // R8: mask only colour 1
    setTab(1, 5, 2, 1, 2, 3); tick("R8 masked write");
    for (int c = 0; c < 3; c++) begin
      pkt(1, 5, c, 9, 0, 1, 1); tick("R8 masked readback");
    end
    // R4: non-IP on rewriting port
    pkt(1, 5, 2, 44, 1, 0, 0); tick("R4 non-IP");
    // R4 R6: port 2 untouched
    setTab(2, 3, 7, 11, 12, 13); tick("R8 port2 write");
    pkt(2, 3, 2, 17, 5, 1, 1); tick("R4 R6 port off");
    // R9: PCP-only on port 2
    setEn(2, 0, 1); tick("R9 pcp only");
    pkt(2, 11, 0, 17, 5, 1, 1); tick("R9 R5 pcp rewrite");
    // R2: idle holds output
    tick("R2 idle hold"); tick("R2 idle hold");
    // R10: out-of-range ports
    setEn(4, 1, 1); tick("R10 write ignored");
    setTab(4, 0, 7, 50, 51, 52); tick("R10 table write ignored");
    pkt(0, 0, 1, 21, 6, 0, 1); tick("R10 no alias");
    pkt(200, 4, 2, 22, 3, 0, 1); tick("R10 far port");
    // R11: same-cycle write and packet
    setTab(3, 9, 7, 40, 41, 42); tick("R8 port3 write");
    setEn(3, 1, 1); pkt(3, 9, 0, 5, 4, 1, 1); tick("R11 old enables");
    setTab(3, 9, 1, 63, 0, 0); pkt(3, 9, 0, 5, 4, 1, 1); tick("R11 old table");
    pkt(3, 9, 0, 5, 4, 1, 1); tick("R11 new table");
    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 5) == 0)
        setEn($urandom_range(0, 5), 1'($urandom), 1'($urandom));
      if ($urandom_range(0, 3) == 0)
        setTab($urandom_range(0, 5), $urandom_range(0, 15), $urandom_range(0, 7),
               $urandom_range(0, 63), $urandom_range(0, 63), $urandom_range(0, 63));
      if ($urandom_range(0, 2) != 0)
        pkt($urandom_range(0, 5), $urandom_range(0, 15), $urandom_range(0, 3),
            $urandom_range(0, 63), $urandom_range(0, 7), 1'($urandom), 1'($urandom));
      tick("R3 mixed traffic");
    end
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule